// File: doc/BRIEF.md
# Stream Port Rule Monitor

A passive observer placed on a single streaming port of an accelerator kernel. It watches the valid, ready, data, byte-enable and last signals together with the kernel's started status. It never drives the stream. When a transfer breaks the packet rules for that port, it raises a sticky error flag. Each class of fault has its own flag. Alongside the flags it keeps a running count of completed packets and of transferred bytes.

The data width is a parameter and must be one of 8, 16, 32, 64, 128, 256 or 512 bits. Any other value stops elaboration. A second parameter says which side the kernel drives. For a kernel output port the kernel drives valid. For a kernel input port the kernel drives ready. That kernel-driven signal is the one that must stay low before the kernel is started.

Integration is simple: tap the port's wires and the started status, then read the flags and counters. A synchronous clear input resets the flags between runs.

Top module: `strm_port_chk`

## Requirements
- R1: A transfer happens only at a clock edge where tvalid_i and tready_i are both high; without one, pkt_cnt_o and byte_cnt_o keep their values.
- R2: On each transfer, byte_cnt_o grows by the number of ones in tkeep_i, visible the cycle after the edge.
- R3: On each transfer with tlast_i high, pkt_cnt_o grows by one, visible the cycle after the edge.
- R4: A transfer with tlast_i low and tkeep_i not all ones (all-zero included) sets err_mid_o.
- R5: A transfer with tlast_i high and a non-zero tkeep_i that is not a run of ones starting at bit 0 sets err_tail_o. On a 4-byte port only 0001, 0011, 0111 and 1111 pass, written bit 3 down to bit 0.
- R6: A transfer with tkeep_i all zeros sets err_zero_o, whatever tlast_i is.
- R7: With started_i low, a high level at any clock edge on the kernel-driven handshake signal sets err_gate_o. That signal is tvalid_i when KERNEL_SRC=1 and tready_i when KERNEL_SRC=0. The other handshake signal never sets this flag.
- R8: After an edge with tvalid_i high and tready_i low, the next edge must see tvalid_i still high and tdata_i, tkeep_i and tlast_i unchanged; otherwise err_hold_o is set.
- R9: A packet is open after a transfer with tlast_i low and until a transfer with tlast_i high. An edge with started_i low while a packet is open sets err_frame_o, and that edge also closes the packet.
- R10: Every flag, once set, stays high until clr_i is sampled high. clr_i clears all flags at that edge and wins over any violation at the same edge.
- R11: After reset all flags and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all error flags |
| started_i | input | 1 | Kernel has been started and is running |
| tvalid_i | input | 1 | Stream valid |
| tready_i | input | 1 | Stream ready |
| tdata_i | input | DATA_W | Stream data |
| tkeep_i | input | DATA_W/8 | Stream byte enables |
| tlast_i | input | 1 | Stream end of packet |
| err_mid_o | output | 1 | Non-final beat with partial byte enables |
| err_tail_o | output | 1 | Final beat with non-contiguous byte enables |
| err_zero_o | output | 1 | Beat with no byte enabled |
| err_gate_o | output | 1 | Kernel-driven handshake high before start |
| err_hold_o | output | 1 | Offered beat withdrawn or changed before acceptance |
| err_frame_o | output | 1 | Kernel stopped inside an open packet |
| pkt_cnt_o | output | CNT_W | Completed packet count |
| byte_cnt_o | output | CNT_W | Transferred byte count |

## Verification
The bench builds the monitor with DATA_W=32 and KERNEL_SRC=1. At that width the byte-enable field has only 4 bits, so the bench can apply all sixteen values as final beats and check each one against the list of legal tails. With KERNEL_SRC=1, valid is the gated signal, so the bench can show that valid before start is caught while ready before start is ignored. Every driven cycle is scored against a reference model built from the requirements. The sequences cover stalls, withdrawn and altered offers, a stop inside a packet and a clear at the same edge as a violation.

// File: rtl/strm_chk_pkg.sv
package strm_chk_pkg;

  localparam int N_ERR = 6;

  // flag vector bit positions
  localparam int E_MID   = 0;
  localparam int E_TAIL  = 1;
  localparam int E_ZERO  = 2;
  localparam int E_GATE  = 3;
  localparam int E_HOLD  = 4;
  localparam int E_FRAME = 5;

  function automatic bit width_ok(input int w);
    case (w)
      8, 16, 32, 64, 128, 256, 512: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/strm_keep_eval.sv
module strm_keep_eval #(
  parameter int KEEP_W = 4,
  localparam int ONES_W = $clog2(KEEP_W + 1)
) (
  input  logic [KEEP_W-1:0] keep_i,
  input  logic              last_i,
  output logic              bad_mid_o,
  output logic              bad_tail_o,
  output logic              zero_o,
  output logic [ONES_W-1:0] ones_o
);

  logic [KEEP_W-1:0] keep_inc;
  logic              all_ones;
  logic              run_from_0;

  assign keep_inc   = keep_i + KEEP_W'(1);
  assign all_ones   = &keep_i;
  assign zero_o     = ~|keep_i;
  // a run of ones from bit 0 has no bit shared with its increment
  assign run_from_0 = ~|(keep_i & keep_inc);

  assign bad_mid_o  = ~last_i & ~all_ones;
  assign bad_tail_o = last_i & ~zero_o & ~run_from_0;

  always_comb begin
    ones_o = '0;
    for (int i = 0; i < KEEP_W; i++) ones_o = ones_o + ONES_W'(keep_i[i]);
  end

endmodule

// File: rtl/strm_hold_watch.sv
module strm_hold_watch #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tvalid_i,
  input  logic              tready_i,
  input  logic [DATA_W-1:0] tdata_i,
  input  logic [KEEP_W-1:0] tkeep_i,
  input  logic              tlast_i,
  output logic              viol_o
);

  logic              pend_q;
  logic [DATA_W-1:0] data_q;
  logic [KEEP_W-1:0] keep_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
      keep_q <= '0;
      last_q <= 1'b0;
    end else begin
      pend_q <= tvalid_i & ~tready_i;
      data_q <= tdata_i;
      keep_q <= tkeep_i;
      last_q <= tlast_i;
    end
  end

  assign viol_o = pend_q & (~tvalid_i | (tdata_i != data_q) |
                            (tkeep_i != keep_q) | (tlast_i != last_q));

endmodule

// File: rtl/strm_frame_track.sv
module strm_frame_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xfer_i,
  input  logic last_i,
  input  logic started_i,
  output logic viol_o
);

  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         open_q <= 1'b0;
    else if (!started_i) open_q <= 1'b0;
    else if (xfer_i)     open_q <= ~last_i;
  end

  assign viol_o = open_q & ~started_i;

endmodule

// File: rtl/strm_stat_cnt.sv
module strm_stat_cnt #(
  parameter int CNT_W  = 32,
  parameter int ONES_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic              last_i,
  input  logic [ONES_W-1:0] ones_i,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_cnt_o  <= '0;
      byte_cnt_o <= '0;
    end else if (xfer_i) begin
      byte_cnt_o <= byte_cnt_o + CNT_W'(ones_i);
      if (last_i) pkt_cnt_o <= pkt_cnt_o + CNT_W'(1);
    end
  end

endmodule

// File: rtl/strm_port_chk.sv
module strm_port_chk
  import strm_chk_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit KERNEL_SRC = 1'b1,
  parameter int CNT_W      = 32,
  localparam int KEEP_W    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              started_i,
  input  logic              tvalid_i,
  input  logic              tready_i,
  input  logic [DATA_W-1:0] tdata_i,
  input  logic [KEEP_W-1:0] tkeep_i,
  input  logic              tlast_i,
  output logic              err_mid_o,
  output logic              err_tail_o,
  output logic              err_zero_o,
  output logic              err_gate_o,
  output logic              err_hold_o,
  output logic              err_frame_o,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);

  localparam int ONES_W = $clog2(KEEP_W + 1);

  if (!width_ok(DATA_W)) begin : g_bad_width
    $error("strm_port_chk: DATA_W must be 8, 16, 32, 64, 128, 256 or 512");
  end

  logic              xfer;
  logic              k_mid, k_tail, k_zero;
  logic [ONES_W-1:0] k_ones;
  logic              hold_viol, frame_viol;
  logic              kdrv;
  logic [N_ERR-1:0]  set_vec, flag_q;

  assign xfer = tvalid_i & tready_i;

  if (KERNEL_SRC) begin : g_src
    assign kdrv = tvalid_i;
  end else begin : g_snk
    assign kdrv = tready_i;
  end

  strm_keep_eval #(.KEEP_W(KEEP_W)) u_keep (
    .keep_i    (tkeep_i),
    .last_i    (tlast_i),
    .bad_mid_o (k_mid),
    .bad_tail_o(k_tail),
    .zero_o    (k_zero),
    .ones_o    (k_ones)
  );

  strm_hold_watch #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tvalid_i(tvalid_i),
    .tready_i(tready_i),
    .tdata_i (tdata_i),
    .tkeep_i (tkeep_i),
    .tlast_i (tlast_i),
    .viol_o  (hold_viol)
  );

  strm_frame_track u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (xfer),
    .last_i   (tlast_i),
    .started_i(started_i),
    .viol_o   (frame_viol)
  );

  strm_stat_cnt #(.CNT_W(CNT_W), .ONES_W(ONES_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xfer_i    (xfer),
    .last_i    (tlast_i),
    .ones_i    (k_ones),
    .pkt_cnt_o (pkt_cnt_o),
    .byte_cnt_o(byte_cnt_o)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[E_MID]   = xfer & k_mid;
    set_vec[E_TAIL]  = xfer & k_tail;
    set_vec[E_ZERO]  = xfer & k_zero;
    set_vec[E_GATE]  = kdrv & ~started_i;
    set_vec[E_HOLD]  = hold_viol;
    set_vec[E_FRAME] = frame_viol;
  end

  // clear has priority over a same-edge set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= '0;
    else if (clr_i)  flag_q <= '0;
    else             flag_q <= flag_q | set_vec;
  end

  assign err_mid_o   = flag_q[E_MID];
  assign err_tail_o  = flag_q[E_TAIL];
  assign err_zero_o  = flag_q[E_ZERO];
  assign err_gate_o  = flag_q[E_GATE];
  assign err_hold_o  = flag_q[E_HOLD];
  assign err_frame_o = flag_q[E_FRAME];

endmodule

// File: rtl/strm_port_chk_sva.sv
module strm_port_chk_sva #(
  parameter int DATA_W     = 64,
  parameter bit KERNEL_SRC = 1'b1,
  parameter int CNT_W      = 32,
  localparam int KEEP_W    = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              started_i,
  input logic              tvalid_i,
  input logic              tready_i,
  input logic [KEEP_W-1:0] tkeep_i,
  input logic              tlast_i,
  input logic              err_mid_o,
  input logic              err_tail_o,
  input logic              err_zero_o,
  input logic              err_gate_o,
  input logic              err_hold_o,
  input logic              err_frame_o,
  input logic [CNT_W-1:0]  pkt_cnt_o,
  input logic [CNT_W-1:0]  byte_cnt_o
);

  logic       hs, kd;
  logic [5:0] flags;
  assign hs    = tvalid_i & tready_i;
  assign kd    = KERNEL_SRC ? tvalid_i : tready_i;
  assign flags = {err_frame_o, err_hold_o, err_gate_o, err_zero_o, err_tail_o, err_mid_o};

  a_r1_idle_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs |=> ($stable(pkt_cnt_o) && $stable(byte_cnt_o)));

  a_r3_pkt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && tlast_i) |=> (pkt_cnt_o == $past(pkt_cnt_o) + CNT_W'(1)));

  a_r4_mid_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !tlast_i && !(&tkeep_i) && !clr_i) |=> err_mid_o);

  a_r6_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && (tkeep_i == '0) && !clr_i) |=> err_zero_o);

  a_r7_gate_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kd && !started_i && !clr_i) |=> err_gate_o);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags & $past(flags)) == $past(flags)));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flags == 6'b0));

endmodule

bind strm_port_chk strm_port_chk_sva #(
  .DATA_W(DATA_W), .KERNEL_SRC(KERNEL_SRC), .CNT_W(CNT_W)
) u_sva (.*);

// File: tb/strm_port_chk_tb.sv
`timescale 1ns/1ps
module strm_port_chk_tb;

  localparam int DW = 32;
  localparam int KW = DW / 8;
  localparam int CW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clr_i = 1'b0, started_i = 1'b0;
  logic          tvalid_i = 1'b0, tready_i = 1'b0, tlast_i = 1'b0;
  logic [DW-1:0] tdata_i = '0;
  logic [KW-1:0] tkeep_i = '0;
  logic          err_mid_o, err_tail_o, err_zero_o, err_gate_o, err_hold_o, err_frame_o;
  logic [CW-1:0] pkt_cnt_o, byte_cnt_o;

  always #4 clk_i = ~clk_i;

  strm_port_chk #(.DATA_W(DW), .KERNEL_SRC(1'b1), .CNT_W(CW)) u_dut (.*);

  typedef struct {
    string       tag;
    logic [5:0]  flags;
    int unsigned pkt;
    int unsigned bytes;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  // reference model state (after the latest edge)
  logic [5:0]    m_flags = '0;
  int unsigned   m_pkt = 0, m_bytes = 0;
  logic          m_open = 1'b0, m_pend = 1'b0, m_plast = 1'b0;
  logic [DW-1:0] m_pdata = '0;
  logic [KW-1:0] m_pkeep = '0;

  // flag vector: {frame, hold, gate, zero, tail, mid}
  task automatic step(input string tag, input logic v, input logic r,
                      input logic [DW-1:0] d, input logic [KW-1:0] k,
                      input logic l, input logic s, input logic c);
    logic       x;
    logic [5:0] set;
    int         ones;
    exp_t       e;
    @(negedge clk_i);
    tvalid_i = v; tready_i = r; tdata_i = d; tkeep_i = k;
    tlast_i = l; started_i = s; clr_i = c;
    x = v && r;
    ones = 0;
    for (int i = 0; i < KW; i++) if (k[i]) ones++;
    set = '0;
    set[0] = x && !l && (k != 4'b1111);
    set[1] = x && l && (k != 4'b0000) && !(k inside {4'b0001, 4'b0011, 4'b0111, 4'b1111});
    set[2] = x && (k == 4'b0000);
    set[3] = v && !s;
    set[4] = m_pend && (!v || d != m_pdata || k != m_pkeep || l != m_plast);
    set[5] = !s && m_open;
    if (x) begin
      m_bytes += ones;
      if (l) m_pkt++;
    end
    if (!s) m_open = 1'b0;
    else if (x) m_open = !l;
    m_pend = v && !r; m_pdata = d; m_pkeep = k; m_plast = l;
    m_flags = c ? 6'b0 : (m_flags | set);
    e.tag = tag; e.flags = m_flags; e.pkt = m_pkt; e.bytes = m_bytes;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic clear(input string tag);
    step(tag, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b1);
  endtask

  // monitor: score each edge's result against the queued expectation
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [5:0] got;
      e = exp_q.pop_front();
      got = {err_frame_o, err_hold_o, err_gate_o, err_zero_o, err_tail_o, err_mid_o};
      n_chk++;
      if (got !== e.flags || pkt_cnt_o !== e.pkt || byte_cnt_o !== e.bytes) begin
        n_bad++;
        $display("FAIL %s: flags=%b pkt=%0d bytes=%0d expected flags=%b pkt=%0d bytes=%0d",
                 e.tag, got, pkt_cnt_o, byte_cnt_o, e.flags, e.pkt, e.bytes);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    started_i = 1'b1;
    @(negedge clk_i);
    n_chk++;
    if ({err_frame_o, err_hold_o, err_gate_o, err_zero_o, err_tail_o, err_mid_o} !== 6'b0 ||
        pkt_cnt_o !== 0 || byte_cnt_o !== 0) begin
      n_bad++;
      $display("FAIL R11: flags=%b pkt=%0d bytes=%0d expected all zero",
               {err_frame_o, err_hold_o, err_gate_o, err_zero_o, err_tail_o, err_mid_o},
               pkt_cnt_o, byte_cnt_o);
    end

    // R1: stalled offer and idle ready do not count
    step("R1", 1'b1, 1'b0, 32'hA5A5_0001, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R1", 1'b1, 1'b0, 32'hA5A5_0001, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R1", 1'b0, 1'b1, 32'h0, 4'b0000, 1'b0, 1'b1, 1'b0);
    step("R1", 1'b1, 1'b0, 32'hA5A5_0002, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R2", 1'b1, 1'b1, 32'hA5A5_0002, 4'b1111, 1'b0, 1'b1, 1'b0);
    // R2/R3: close packet, then single-beat packets with short tails
    step("R3", 1'b1, 1'b1, 32'h1111_2222, 4'b0111, 1'b1, 1'b1, 1'b0);
    step("R3", 1'b1, 1'b1, 32'h3333_4444, 4'b0001, 1'b1, 1'b1, 1'b0);
    step("R2", 1'b1, 1'b1, 32'h5555_6666, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R2", 1'b1, 1'b1, 32'h7777_8888, 4'b0011, 1'b1, 1'b1, 1'b0);
    idle("R1", 2);

    // R4: partial enables on a non-final beat
    step("R4", 1'b1, 1'b1, 32'hDEAD_0001, 4'b0111, 1'b0, 1'b1, 1'b0);
    step("R4", 1'b1, 1'b1, 32'hDEAD_0002, 4'b1111, 1'b1, 1'b1, 1'b0);
    idle("R10", 3);
    clear("R10");
    step("R4", 1'b1, 1'b1, 32'hDEAD_0003, 4'b1110, 1'b0, 1'b1, 1'b0);
    step("R4", 1'b1, 1'b1, 32'hDEAD_0004, 4'b1111, 1'b1, 1'b1, 1'b0);
    clear("R10");

    // R5/R6: every byte-enable value on a final beat
    for (int kv = 0; kv < 16; kv++) begin
      step((kv == 0) ? "R6" : "R5", 1'b1, 1'b1, 32'hC0DE_0000 + kv, 4'(kv), 1'b1, 1'b1, 1'b0);
      clear("R10");
    end

    // R6: zero enables on a non-final beat
    step("R6", 1'b1, 1'b1, 32'hF00D_0001, 4'b0000, 1'b0, 1'b1, 1'b0);
    step("R6", 1'b1, 1'b1, 32'hF00D_0002, 4'b1111, 1'b1, 1'b1, 1'b0);
    clear("R10");

    // R7: ready before start is not gated, valid is
    step("R7", 1'b0, 1'b1, 32'h0, 4'b0000, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b0, 1'b0, 32'h0, 4'b0000, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 1'b1, 32'hBEEF_0001, 4'b1111, 1'b1, 1'b0, 1'b0);
    idle("R7", 1);
    clear("R10");

    // R8: offer changed, then offer withdrawn
    step("R8", 1'b1, 1'b0, 32'h0000_00AA, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b0, 32'h0000_00AA, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b1, 32'h0000_00AA, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b1, 32'h0000_00AB, 4'b1111, 1'b1, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b0, 32'h0000_00BB, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b0, 32'h0000_00BC, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b1, 32'h0000_00BC, 4'b1111, 1'b1, 1'b1, 1'b0);
    clear("R10");
    step("R8", 1'b1, 1'b0, 32'h0000_00CC, 4'b0011, 1'b1, 1'b1, 1'b0);
    step("R8", 1'b0, 1'b0, 32'h0000_00CC, 4'b0011, 1'b1, 1'b1, 1'b0);
    clear("R10");
    step("R8", 1'b1, 1'b0, 32'h0000_00DD, 4'b0011, 1'b1, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b1, 32'h0000_00DD, 4'b0001, 1'b1, 1'b1, 1'b0);
    clear("R10");

    // R9: stop inside a packet, then stop after a complete one
    step("R9", 1'b1, 1'b1, 32'h9999_0001, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R9", 1'b0, 1'b0, 32'h0, 4'b0000, 1'b0, 1'b0, 1'b0);
    step("R9", 1'b0, 1'b0, 32'h0, 4'b0000, 1'b0, 1'b1, 1'b1);
    step("R9", 1'b1, 1'b1, 32'h9999_0002, 4'b1111, 1'b0, 1'b1, 1'b0);
    step("R9", 1'b1, 1'b1, 32'h9999_0003, 4'b1111, 1'b1, 1'b1, 1'b0);
    step("R9", 1'b0, 1'b0, 32'h0, 4'b0000, 1'b0, 1'b0, 1'b0);
    idle("R9", 1);

    // R10: clear at the same edge as a violation wins
    step("R10", 1'b1, 1'b1, 32'hAAAA_0001, 4'b0000, 1'b1, 1'b1, 1'b1);
    idle("R10", 2);

    repeat (3) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule